// File: doc/BRIEF.md
# Forest-Fire Rule Engine with Wind

This block applies one step of a four-state forest-fire cellular automaton to a data word of sixteen 2-bit cells. One processing element per cell works in parallel. Each cell sees its own state and its eight Moore neighbours. The neighbours come from three window rows: the row above, the centre row and the row below. Each row carries the sixteen cells of the word plus one halo cell on the west side and one on the east side. The updated word is registered, and it comes with a flag that is set when any cell changed.

A small rule-parameter input selects between two models. In the uniform model, a burning neighbour in any of the eight directions ignites a tree. In the wind model, only burning neighbours on the upwind side can ignite a tree. The wind speed field widens or narrows that upwind arc. Ground and burnt cells never change, so they act as fire barriers. A memory sequencer upstream streams one window per cycle into the block and stores each result in the destination bank.

Top module: `ffwind_engine`

## Requirements
- R1: A cell encoded 2'b10 (fire) always becomes 2'b11 (burnt tree) in the next result, whatever its neighbours are.
- R2: Cells encoded 2'b00 (ground) and 2'b11 (burnt tree) come out unchanged, even next to fire.
- R3: A tree cell (2'b01) with no burning neighbour in an allowed direction stays a tree. Ground, tree and burnt neighbours never ignite it.
- R4: When rule_param[0] is 0, or the speed field rule_param[5:4] is 0, a tree ignites (becomes 2'b10) if any of its eight neighbours burns. This includes the halo cells at the west and east word edges.
- R5: When rule_param[0] is 1 and the speed is 2 or 3, a tree ignites only from the single upwind neighbour. rule_param[3:1] gives the direction the wind blows toward, clockwise: 0=N, 1=NE, 2=E, 3=SE, 4=S, 5=SW, 6=W, 7=NW. The upwind neighbour is the one lying in the opposite direction (code+4 mod 8). North is the row above, and east is the higher cell index.
- R6: When rule_param[0] is 1 and the speed is 1, a tree ignites from the upwind neighbour or from either of the two compass neighbours next to it (codes upwind±1 mod 8).
- R7: word_changed is 1 exactly when out_word differs from the centre word it was computed from.
- R8: A result appears one clock after in_valid is sampled high, with out_valid high for that cycle. When in_valid is low, out_valid is 0 and out_word and word_changed hold their values.
- R9: After reset, out_valid, out_word and word_changed are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Window rows and rule parameters are valid this cycle |
| row_up | input | 36 | Row above: cell j at bits [2j+1:2j]; j=0 is the west halo, j=1..16 are word cells 0..15, j=17 is the east halo |
| row_mid | input | 36 | Centre row, same layout; its cells 1..16 are the word being updated |
| row_dn | input | 36 | Row below, same layout |
| rule_param | input | 6 | [0] wind enable, [3:1] wind direction, [5:4] wind speed |
| out_valid | output | 1 | out_word holds a fresh result |
| out_word | output | 32 | Updated word: cell i at bits [2i+1:2i] |
| word_changed | output | 1 | Some cell of the result differs from its input state |

## Verification
Ignition of a tree and the wind-direction mask act in the same cycle, and the directed sweep provokes exactly that. The sweep places a single burning neighbour in each of the eight compass positions around one tree. It repeats this under every wind direction and every speed, and each outcome is judged against a bench model that derives the upwind arc from its own direction offsets. The change flag is also computed in the same cycle as a fire burning out. Words holding only barrier cells check that the flag stays low. Seeded random windows mix all four states with random rule parameters.

// File: rtl/ffwind_pkg.sv
package ffwind_pkg;
   localparam int CW   = 2;
   localparam int DIRS = 8;

   typedef enum logic [CW-1:0] {
      C_GROUND = 2'b00,
      C_TREE   = 2'b01,
      C_FIRE   = 2'b10,
      C_BURNT  = 2'b11
   } cell_e;

   typedef struct packed {
      logic [1:0] spd;
      logic [2:0] dir;
      logic       en;
   } wind_cfg_t;

   // compass codes, clockwise from north
   localparam logic [2:0] D_N  = 3'd0;
   localparam logic [2:0] D_NE = 3'd1;
   localparam logic [2:0] D_E  = 3'd2;
   localparam logic [2:0] D_SE = 3'd3;
   localparam logic [2:0] D_S  = 3'd4;
   localparam logic [2:0] D_SW = 3'd5;
   localparam logic [2:0] D_W  = 3'd6;
   localparam logic [2:0] D_NW = 3'd7;
endpackage

// File: rtl/ffwind_dir_mask.sv
module ffwind_dir_mask
   import ffwind_pkg::*;
(
   input  wind_cfg_t        cfg,
   output logic [DIRS-1:0]  allow
);
   logic [2:0]      upwind;
   logic [DIRS-1:0] up_oh;
   logic [DIRS-1:0] arc;

   always_comb begin
      upwind = cfg.dir + 3'd4;
      up_oh  = '0;
      up_oh[upwind] = 1'b1;
      arc    = up_oh | {up_oh[DIRS-2:0], up_oh[DIRS-1]}
                     | {up_oh[0], up_oh[DIRS-1:1]};
      if (!cfg.en || cfg.spd == 2'd0)
         allow = '1;
      else if (cfg.spd == 2'd1)
         allow = arc;
      else
         allow = up_oh;
   end
endmodule

// File: rtl/ffwind_cell_pe.sv
module ffwind_cell_pe
   import ffwind_pkg::*;
(
   input  logic [CW-1:0]             cur,
   input  logic [DIRS-1:0][CW-1:0]   nbr,
   input  logic [DIRS-1:0]           allow,
   output logic [CW-1:0]             nxt,
   output logic                      diff
);
   logic [DIRS-1:0] hot;
   logic            spark;

   always_comb begin
      for (int k = 0; k < DIRS; k++)
         hot[k] = (nbr[k] == C_FIRE) && allow[k];
      spark = |hot;
      case (cur)
         C_TREE:  nxt = spark ? C_FIRE : C_TREE;
         C_FIRE:  nxt = C_BURNT;
         default: nxt = cur;
      endcase
      diff = (nxt != cur);
   end
endmodule

// File: rtl/ffwind_change_det.sv
module ffwind_change_det #(
   parameter int CELLS       = 16,
   parameter int GROUP       = 4,
   parameter bit REDUCE_TREE = 1'b1
) (
   input  logic [CELLS-1:0] diff,
   output logic             any
);
   localparam int NGRP = (CELLS + GROUP - 1) / GROUP;
   localparam int PADW = NGRP * GROUP;

   generate
      if (REDUCE_TREE && NGRP > 1) begin : g_tree
         logic [PADW-1:0] padded;
         logic [NGRP-1:0] grp_any;
         assign padded = PADW'(diff);
         for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign grp_any[g] = |padded[g*GROUP +: GROUP];
         end
         assign any = |grp_any;
      end else begin : g_flat
         assign any = |diff;
      end
   endgenerate
endmodule

// File: rtl/ffwind_engine.sv
module ffwind_engine
   import ffwind_pkg::*;
#(
   parameter int CELLS       = 16,
   parameter int GROUP       = 4,
   parameter bit REDUCE_TREE = 1'b1,
   localparam int ROW_W      = (CELLS + 2) * CW,
   localparam int WORD_W     = CELLS * CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ROW_W-1:0]  row_up,
   input  logic [ROW_W-1:0]  row_mid,
   input  logic [ROW_W-1:0]  row_dn,
   input  logic [5:0]        rule_param,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic              word_changed
);
   generate
      if (CELLS < 1) begin : g_bad_cells
         $error("ffwind_engine: CELLS must be at least 1");
      end
      if (GROUP < 1) begin : g_bad_group
         $error("ffwind_engine: GROUP must be at least 1");
      end
      if (DIRS != 8 || CW != 2) begin : g_bad_pkg
         $error("ffwind_engine: package geometry must be 8 directions of 2-bit cells");
      end
   endgenerate

   wind_cfg_t                         cfg;
   logic [DIRS-1:0]                   allow;
   logic [CELLS-1:0][DIRS-1:0][CW-1:0] nbr;
   logic [WORD_W-1:0]                 next_word;
   logic [CELLS-1:0]                  diff;
   logic                              any_diff;

   assign cfg = wind_cfg_t'(rule_param);

   ffwind_dir_mask u_mask (
      .cfg   (cfg),
      .allow (allow)
   );

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_pe
         localparam int J = i + 1;
         assign nbr[i][D_N]  = row_up [CW*J       +: CW];
         assign nbr[i][D_NE] = row_up [CW*(J+1)   +: CW];
         assign nbr[i][D_E]  = row_mid[CW*(J+1)   +: CW];
         assign nbr[i][D_SE] = row_dn [CW*(J+1)   +: CW];
         assign nbr[i][D_S]  = row_dn [CW*J       +: CW];
         assign nbr[i][D_SW] = row_dn [CW*(J-1)   +: CW];
         assign nbr[i][D_W]  = row_mid[CW*(J-1)   +: CW];
         assign nbr[i][D_NW] = row_up [CW*(J-1)   +: CW];

         ffwind_cell_pe u_pe (
            .cur   (row_mid[CW*J +: CW]),
            .nbr   (nbr[i]),
            .allow (allow),
            .nxt   (next_word[CW*i +: CW]),
            .diff  (diff[i])
         );
      end
   endgenerate

   ffwind_change_det #(
      .CELLS       (CELLS),
      .GROUP       (GROUP),
      .REDUCE_TREE (REDUCE_TREE)
   ) u_chg (
      .diff (diff),
      .any  (any_diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_word     <= '0;
         word_changed <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word     <= next_word;
            word_changed <= any_diff;
         end
      end
   end
endmodule

// File: rtl/ffwind_checker.sv
module ffwind_checker
   import ffwind_pkg::*;
#(
   parameter int CELLS = 16,
   localparam int ROW_W  = (CELLS + 2) * CW,
   localparam int WORD_W = CELLS * CW
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ROW_W-1:0]  row_up,
   input logic [ROW_W-1:0]  row_mid,
   input logic [ROW_W-1:0]  row_dn,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_word,
   input logic              word_changed
);
   logic no_fire;
   always_comb begin
      no_fire = 1'b1;
      for (int j = 0; j < CELLS + 2; j++) begin
         if (row_up[CW*j +: CW] == C_FIRE || row_mid[CW*j +: CW] == C_FIRE
             || row_dn[CW*j +: CW] == C_FIRE)
            no_fire = 1'b0;
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_word) && $stable(word_changed))); // R8

   AST_CHANGED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (word_changed == (out_word != $past(row_mid[WORD_W+CW-1:CW])))); // R7

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         AST_FIRE_BURNS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && row_mid[CW*(i+1) +: CW] == C_FIRE)
            |=> out_word[CW*i +: CW] == C_BURNT); // R1

         AST_BARRIER_STILL: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (row_mid[CW*(i+1) +: CW] == C_GROUND
                          || row_mid[CW*(i+1) +: CW] == C_BURNT))
            |=> out_word[CW*i +: CW] == $past(row_mid[CW*(i+1) +: CW])); // R2

         AST_NO_SPARK: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && no_fire && row_mid[CW*(i+1) +: CW] == C_TREE)
            |=> out_word[CW*i +: CW] == C_TREE); // R3
      end
   endgenerate
endmodule

bind ffwind_engine ffwind_checker #(.CELLS(CELLS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .row_up       (row_up),
   .row_mid      (row_mid),
   .row_dn       (row_dn),
   .out_valid    (out_valid),
   .out_word     (out_word),
   .word_changed (word_changed)
);

// File: tb/sim_ffwind_engine.sv
`timescale 1ns/1ps
module sim_ffwind_engine;
   localparam int CELLS  = 16;
   localparam int ROW_W  = (CELLS + 2) * 2;
   localparam int WORD_W = CELLS * 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [ROW_W-1:0]  row_up = '0, row_mid = '0, row_dn = '0;
   logic [5:0]        rule_param = '0;
   logic              out_valid;
   logic [WORD_W-1:0] out_word;
   logic              word_changed;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ffwind_engine u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .row_up(row_up), .row_mid(row_mid), .row_dn(row_dn),
      .rule_param(rule_param), .out_valid(out_valid),
      .out_word(out_word), .word_changed(word_changed)
   );

   function automatic logic [1:0] cell_of(logic [ROW_W-1:0] r, int j);
      return r[2*j +: 2];
   endfunction

   function automatic bit dir_open(logic [5:0] p, int k);
      int u;
      if (!p[0] || p[5:4] == 2'd0) return 1'b1;
      u = (int'(p[3:1]) + 4) % 8;
      if (k == u) return 1'b1;
      if (p[5:4] == 2'd1 && (k == (u + 1) % 8 || k == (u + 7) % 8)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [WORD_W-1:0] ref_next(logic [ROW_W-1:0] up,
         logic [ROW_W-1:0] mid, logic [ROW_W-1:0] dn, logic [5:0] p);
      logic [WORD_W-1:0] res;
      for (int i = 0; i < CELLS; i++) begin
         logic [1:0] s;
         bit lit;
         s = cell_of(mid, i + 1);
         lit = 1'b0;
         for (int k = 0; k < 8; k++) begin
            int dx, dy;
            logic [1:0] n;
            case (k)
               0: begin dx = 0;  dy = -1; end
               1: begin dx = 1;  dy = -1; end
               2: begin dx = 1;  dy = 0;  end
               3: begin dx = 1;  dy = 1;  end
               4: begin dx = 0;  dy = 1;  end
               5: begin dx = -1; dy = 1;  end
               6: begin dx = -1; dy = 0;  end
               default: begin dx = -1; dy = -1; end
            endcase
            n = (dy < 0) ? cell_of(up, i + 1 + dx)
              : (dy > 0) ? cell_of(dn, i + 1 + dx) : cell_of(mid, i + 1 + dx);
            if (n == 2'b10 && dir_open(p, k)) lit = 1'b1;
         end
         case (s)
            2'b01:   res[2*i +: 2] = lit ? 2'b10 : 2'b01;
            2'b10:   res[2*i +: 2] = 2'b11;
            default: res[2*i +: 2] = s;
         endcase
      end
      return res;
   endfunction

   task automatic check(string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one window, sample the registered result one cycle later
   task automatic apply(string tag, logic [ROW_W-1:0] up, logic [ROW_W-1:0] mid,
                        logic [ROW_W-1:0] dn, logic [5:0] p);
      logic [WORD_W-1:0] exp;
      @(negedge clk);
      row_up = up; row_mid = mid; row_dn = dn; rule_param = p; in_valid = 1'b1;
      exp = ref_next(up, mid, dn, p);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " word"}, out_word, exp);
      check("R8 valid", WORD_W'(out_valid), WORD_W'(1));
      check("R7 changed", WORD_W'(word_changed), WORD_W'(exp != mid[WORD_W+1:2]));
   endtask

   function automatic logic [ROW_W-1:0] put(logic [ROW_W-1:0] r, int j, logic [1:0] v);
      logic [ROW_W-1:0] t;
      t = r;
      t[2*j +: 2] = v;
      return t;
   endfunction

   function automatic logic [ROW_W-1:0] fill(logic [1:0] v);
      logic [ROW_W-1:0] t;
      for (int j = 0; j < CELLS + 2; j++) t[2*j +: 2] = v;
      return t;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [WORD_W-1:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 out_valid", WORD_W'(out_valid), '0);
      check("R9 out_word", out_word, '0);
      check("R9 word_changed", WORD_W'(word_changed), '0);
      rst_n = 1'b1;

      // R1 all burning
      apply("R1", fill(2'b10), fill(2'b10), fill(2'b10), 6'b0);
      // R2 barrier cells surrounded by fire: word unchanged, flag low
      begin
         logic [ROW_W-1:0] m;
         m = fill(2'b10);
         for (int j = 1; j <= CELLS; j++) m = put(m, j, (j % 2) ? 2'b00 : 2'b11);
         apply("R2", fill(2'b10), m, fill(2'b10), 6'b0);
      end
      // R3 trees with ground/tree/burnt neighbours only
      apply("R3", fill(2'b11), fill(2'b01), fill(2'b00), 6'b0);
      // R4 halo edges ignite outer cells with wind off
      apply("R4 east halo", fill(2'b00), put(fill(2'b01), CELLS + 1, 2'b10), fill(2'b00), 6'b0);
      apply("R4 west halo", put(fill(2'b00), 0, 2'b10), fill(2'b01), fill(2'b00), 6'b0);
      apply("R4 speed0", fill(2'b00), put(fill(2'b01), 0, 2'b10), fill(2'b00), 6'b001111);

      // R5/R6 sweep: one tree at cell 5, one burning neighbour in direction k
      for (int d = 0; d < 8; d++) begin
         for (int s = 1; s < 4; s++) begin
            for (int k = 0; k < 8; k++) begin
               logic [ROW_W-1:0] u, m, n;
               int dx, dy;
               case (k)
                  0: begin dx = 0;  dy = -1; end
                  1: begin dx = 1;  dy = -1; end
                  2: begin dx = 1;  dy = 0;  end
                  3: begin dx = 1;  dy = 1;  end
                  4: begin dx = 0;  dy = 1;  end
                  5: begin dx = -1; dy = 1;  end
                  6: begin dx = -1; dy = 0;  end
                  default: begin dx = -1; dy = -1; end
               endcase
               u = '0; n = '0;
               m = put('0, 6, 2'b01);
               if (dy < 0) u = put(u, 6 + dx, 2'b10);
               else if (dy > 0) n = put(n, 6 + dx, 2'b10);
               else m = put(m, 6 + dx, 2'b10);
               apply((s == 1) ? "R6" : "R5", u, m, n, {2'(s), 3'(d), 1'b1});
            end
         end
      end

      // R8 hold while idle
      apply("R8 prep", fill(2'b01), put(fill(2'b01), 3, 2'b10), fill(2'b00), 6'b0);
      held = out_word;
      @(negedge clk);
      row_mid = fill(2'b10); row_up = fill(2'b10);
      @(negedge clk);
      check("R8 idle valid", WORD_W'(out_valid), '0);
      check("R8 idle hold", out_word, held);

      // random windows
      for (int t = 0; t < 400; t++) begin
         logic [5:0] p;
         p = 6'($urandom);
         apply((!p[0] || p[5:4] == 0) ? "R4" : (p[5:4] == 1) ? "R6" : "R5",
               ROW_W'({$urandom, $urandom}), ROW_W'({$urandom, $urandom}),
               ROW_W'({$urandom, $urandom}), p);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule